// File: doc/BRIEF.md
# SD Card Clock Divider with Glitch-Free Gating

This block produces the SD card clock from a fixed base clock. The base clock is nominally 150 MHz and also clocks the block's register. A single 16-bit control register is written through a strobe and read back in full. It selects a divisor and starts the internal divided clock. Once the divided clock has run for a fixed number of periods, a read-only flag reports that it is stable. The card-facing output stays low until a separate card-enable bit is set.

The divisor set is 1, 2, 3, 4, 8, 16, 32, 64, 128 and 256. The divider code is half the divisor, so code 1 gives /2 and code 128 gives /256. Two codes break that pattern: code 0 passes the base clock through undivided, and code 3 gives /3. Software stops the clock by writing all zeros. It then brings the clock up by writing a code with the internal enable set, polls for the stable flag, and finally sets the card enable. The output is gated only while the divided clock is low, so no runt pulse reaches the card.

Top module: `sd_clkgen`

## Requirements
- R1: After reset the register reads 0x0000 and the card clock output is low.
- R2: Register fields: divider code in bits 15:8, internal enable in bit 0, stable flag in bit 1 (read-only), card enable in bit 2. Bits 7:3 always read 0, and writes to bits 1 and 7:3 have no effect.
- R3: With the card clock enabled, the output period in base cycles is: code 0 gives 1, code 1 gives 2, code 2 gives 4, code 3 gives 3, code 4 gives 8, code 8 gives 16, code 16 gives 32, code 32 gives 64, code 64 gives 128 and code 128 gives 256.
- R4: Any other code selects the smallest supported divisor that is at least twice the code. Codes 5, 6 and 7 give 16, code 9 gives 32, and every code above 128 gives 256.
- R5: For even divisors the output is high for half the period. For /3 it is high for one base cycle, and for /1 it follows the base clock.
- R6: After a write that sets the internal enable, the stable flag rises after 8 divided-clock periods, plus at most one base cycle. The flag never reads 1 while the internal enable reads 0.
- R7: The stable flag reads 0 on the first read after a write that clears the internal enable or that changes the divider code.
- R8: Writing 0x0000 clears the whole register at once, and the card clock output stays low from then on.
- R9: While the card enable is 0 the output stays low even though the divider runs. Setting or clearing the card enable never shortens a high pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, also clocks the register |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register readback |
| sd_clk_out | output | 1 | Gated card clock |

## Verification
The hardest case to reach from the ports is a change of the card enable while the divided clock is partway through a high phase. That is where a runt pulse would appear. The card-enable write cannot be lined up with a phase from outside the block. Instead, a pulse-width monitor watches every output pulse while the card enable is set and again while it is cleared, and it does this for all fifteen table codes, so the write lands at many different points in the divider phase. The stable latency is counted sample by sample against eight times the expected divisor. This ties the flag to the divisor that each code selects.

// File: rtl/sd_clkgen_pkg.sv
`timescale 1ns/1ps
package sd_clkgen_pkg;
  localparam int REG_W     = 16;
  localparam int CODE_W    = 8;
  localparam int DIV_W     = CODE_W + 1;
  localparam int CODE_LSB  = 8;
  localparam int INT_BIT   = 0;
  localparam int STB_BIT   = 1;
  localparam int CARD_BIT  = 2;
  localparam int RSV_LSB   = 3;
  localparam int RSV_W     = CODE_LSB - RSV_LSB;

  // Map a divider code to a divisor in base cycles.
  function automatic logic [DIV_W-1:0] code_to_divisor(input logic [CODE_W-1:0] c);
    logic [DIV_W-1:0] d;
    int msb;
    msb = 0;
    for (int i = 0; i < CODE_W; i++) begin
      if (c[i]) msb = i;
    end
    if (c == '0)
      d = DIV_W'(1);
    else if (c == CODE_W'(3))
      d = DIV_W'(3);
    else if ((c & (c - CODE_W'(1))) == '0)
      d = {c, 1'b0};
    else if (msb == CODE_W - 1)
      d = DIV_W'(1) << (DIV_W - 1);
    else
      d = DIV_W'(4) << msb;
    return d;
  endfunction

  // Number of base cycles the divided clock spends high.
  function automatic logic [DIV_W-1:0] high_cycles(input logic [DIV_W-1:0] d);
    if (d == DIV_W'(1) || d == DIV_W'(3))
      return DIV_W'(1);
    return d >> 1;
  endfunction
endpackage

// File: rtl/sd_clkgen_regs.sv
`timescale 1ns/1ps
module sd_clkgen_regs
  import sd_clkgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_int,
  input  logic              wr_card,
  output logic [CODE_W-1:0] code_q,
  output logic              int_q,
  output logic              card_q,
  output logic              stop_now,
  output logic              restart
);
  assign stop_now = wr_en && !wr_int;
  assign restart  = stop_now || (wr_en && (wr_code != code_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      int_q  <= 1'b0;
      card_q <= 1'b0;
    end else if (wr_en) begin
      code_q <= wr_code;
      int_q  <= wr_int;
      card_q <= wr_card;
    end
  end
endmodule

// File: rtl/sd_clkgen_divider.sv
`timescale 1ns/1ps
module sd_clkgen_divider
  import sd_clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [DIV_W-1:0] divisor,
  input  logic [DIV_W-1:0] high_len,
  output logic             div_q,
  output logic [DIV_W-1:0] cnt_q,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic             active;
  logic [DIV_W-1:0] cnt_nxt;

  assign active = run && !clr;

  always_comb begin
    if (cnt_q >= divisor - DIV_W'(1))
      cnt_nxt = '0;
    else
      cnt_nxt = cnt_q + DIV_W'(1);
  end

  assign rise_evt = active && (cnt_nxt == '0);
  assign fall_evt = active && (divisor != DIV_W'(1)) && (cnt_nxt == high_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (!active) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      div_q <= (cnt_nxt < high_len);
    end
  end
endmodule

// File: rtl/sd_clkgen_stable.sv
`timescale 1ns/1ps
module sd_clkgen_stable #(
  parameter int PERIODS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  logic rise_evt,
  output logic stable
);
  localparam int CNT_W = $clog2(PERIODS + 1);
  logic [CNT_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      seen_q <= '0;
    else if (!run || clr)
      seen_q <= '0;
    else if (rise_evt && (seen_q != CNT_W'(PERIODS)))
      seen_q <= seen_q + CNT_W'(1);
  end

  assign stable = (seen_q == CNT_W'(PERIODS));
endmodule

// File: rtl/sd_clkgen_gate.sv
`timescale 1ns/1ps
module sd_clkgen_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic stop_now,
  input  logic fall_evt,
  input  logic card_en,
  input  logic bypass,
  input  logic div_q,
  output logic gate_q,
  output logic gate_neg,
  output logic sd_clk
);
  // Divided path: the enable only moves on the edge that drives div_q low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gate_q <= 1'b0;
    else if (!run || stop_now)
      gate_q <= 1'b0;
    else if (fall_evt)
      gate_q <= card_en;
  end

  // Undivided path: the enable moves while the base clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)
      gate_neg <= 1'b0;
    else
      gate_neg <= card_en && run;
  end

  assign sd_clk = bypass ? (clk & gate_neg) : (div_q & gate_q);
endmodule

// File: rtl/sd_clkgen.sv
`timescale 1ns/1ps
module sd_clkgen
  import sd_clkgen_pkg::*;
#(
  parameter int STABLE_PERIODS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             sd_clk_out
);
  logic [CODE_W-1:0] code_q;
  logic              int_q;
  logic              card_q;
  logic              stop_now;
  logic              restart;
  logic [DIV_W-1:0]  divisor;
  logic [DIV_W-1:0]  high_len;
  logic              bypass;
  logic              div_level;
  logic [DIV_W-1:0]  div_cnt;
  logic              rise_evt;
  logic              fall_evt;
  logic              stable;
  logic              gate_on;
  logic              gate_neg;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[CODE_LSB-1:RSV_LSB], wr_data[STB_BIT]};

  sd_clkgen_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_code  (wr_data[CODE_LSB +: CODE_W]),
    .wr_int   (wr_data[INT_BIT]),
    .wr_card  (wr_data[CARD_BIT]),
    .code_q   (code_q),
    .int_q    (int_q),
    .card_q   (card_q),
    .stop_now (stop_now),
    .restart  (restart)
  );

  assign divisor  = code_to_divisor(code_q);
  assign high_len = high_cycles(divisor);
  assign bypass   = (divisor == DIV_W'(1));

  sd_clkgen_divider u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (int_q),
    .clr      (restart),
    .divisor  (divisor),
    .high_len (high_len),
    .div_q    (div_level),
    .cnt_q    (div_cnt),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  sd_clkgen_stable #(.PERIODS(STABLE_PERIODS)) u_stable (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (int_q),
    .clr      (restart),
    .rise_evt (rise_evt),
    .stable   (stable)
  );

  sd_clkgen_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (int_q),
    .stop_now (stop_now),
    .fall_evt (fall_evt),
    .card_en  (card_q),
    .bypass   (bypass),
    .div_q    (div_level),
    .gate_q   (gate_on),
    .gate_neg (gate_neg),
    .sd_clk   (sd_clk_out)
  );

  always_comb begin
    rd_data                       = '0;
    rd_data[CODE_LSB +: CODE_W]   = code_q;
    rd_data[INT_BIT]              = int_q;
    rd_data[STB_BIT]              = stable;
    rd_data[CARD_BIT]             = card_q;
  end
endmodule

// File: rtl/sd_clkgen_chk.sv
`timescale 1ns/1ps
module sd_clkgen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        div_q,
  input logic        gate_q,
  input logic        bypass,
  input logic [8:0]  cnt,
  input logic [8:0]  divisor
);
  assert_zero_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 16'h0000) |=> (rd_data == 16'h0000 && !div_q && !gate_q));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:3] == 5'd0);

  assert_stable_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1] |-> rd_data[0]);

  assert_stable_drop_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[0]) |=> !rd_data[1]);

  assert_stable_drop_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15:8] != rd_data[15:8]) |=> !rd_data[1]);

  assert_gate_when_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && gate_q != $past(gate_q)) |-> !div_q);

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < divisor);

  assert_third_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == 9'd3 && $rose(div_q)) |=> !div_q);
endmodule

bind sd_clkgen sd_clkgen_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .div_q   (div_level),
  .gate_q  (gate_on),
  .bypass  (bypass),
  .cnt     (div_cnt),
  .divisor (divisor)
);

// File: tb/sd_clkgen_bench.sv
`timescale 1ns/1ps
module sd_clkgen_bench;
  localparam real TCLK = 8.0;
  localparam int  NVEC = 15;
  // {legal flag, code, divisor}
  localparam logic [31:0] VEC [0:NVEC-1] = '{
    {7'd0, 1'b1, 8'd0,   16'd1},
    {7'd0, 1'b1, 8'd1,   16'd2},
    {7'd0, 1'b1, 8'd2,   16'd4},
    {7'd0, 1'b1, 8'd3,   16'd3},
    {7'd0, 1'b1, 8'd4,   16'd8},
    {7'd0, 1'b1, 8'd8,   16'd16},
    {7'd0, 1'b1, 8'd16,  16'd32},
    {7'd0, 1'b1, 8'd32,  16'd64},
    {7'd0, 1'b1, 8'd64,  16'd128},
    {7'd0, 1'b1, 8'd128, 16'd256},
    {7'd0, 1'b0, 8'd5,   16'd16},
    {7'd0, 1'b0, 8'd6,   16'd16},
    {7'd0, 1'b0, 8'd7,   16'd16},
    {7'd0, 1'b0, 8'd9,   16'd32},
    {7'd0, 1'b0, 8'd200, 16'd256}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        sd_clk_out;

  int  errors = 0;
  int  checks = 0;
  bit  mon_on = 1'b0;
  bit  rise_ok = 1'b0;
  real exp_high = 0.0;
  real t_rise = 0.0;

  always #(TCLK/2) clk = ~clk;

  sd_clkgen u_sd_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .sd_clk_out (sd_clk_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  // Count samples in which the output is high over n base cycles.
  task automatic high_samples(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      if (sd_clk_out) hits++;
      @(negedge clk);
    end
  endtask

  // Pulse-width monitor: every pulse that starts while enabled must be full.
  always @(posedge sd_clk_out) begin
    t_rise = $realtime;
    rise_ok = mon_on;
  end
  always @(negedge sd_clk_out) begin
    if (rise_ok)
      chk("R5/R9 pulse width ps", int'(($realtime - t_rise) * 1000.0),
          int'(exp_high * 1000.0));
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat;
    int hits;
    real t0, t1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rd_data at reset", int'(rd_data), 0);
    chk("R1 sd_clk_out at reset", int'(sd_clk_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 rd_data after reset release", int'(rd_data), 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] code;
      int n;
      bit legal;
      code  = VEC[v][23:16];
      n     = int'(VEC[v][15:0]);
      legal = VEC[v][24];
      exp_high = (n == 1) ? TCLK/2 : ((n == 3) ? TCLK : TCLK * (n / 2));

      wr(16'h0000);
      chk("R8 zero write readback", int'(rd_data), 0);

      wr({code, 8'h01});
      lat = 0;
      while (!rd_data[1] && lat < 8 * n + 4) begin
        lat++;
        @(negedge clk);
      end
      chk("R6 stable latency in [8N,8N+1]", int'(lat >= 8 * n && lat <= 8 * n + 1), 1);
      chk("R2 readback with stable", int'(rd_data), int'({code, 8'h03}));

      high_samples(2 * n + 2, hits);
      chk("R9 output low with card enable clear", hits, 0);

      mon_on = 1'b1;
      wr({code, 8'h05});
      @(posedge sd_clk_out);
      t0 = $realtime;
      @(posedge sd_clk_out);
      t1 = $realtime;
      if (legal)
        chk("R3 period ps", int'((t1 - t0) * 1000.0), int'(TCLK * n * 1000.0));
      else
        chk("R4 period ps", int'((t1 - t0) * 1000.0), int'(TCLK * n * 1000.0));
      @(posedge sd_clk_out);
      @(negedge clk);

      wr({code, 8'h01});
      repeat (n + 2) @(negedge clk);
      mon_on = 1'b0;
      high_samples(2 * n + 2, hits);
      chk("R9 output low after card disable", hits, 0);
    end

    // R2: reserved and read-only bits are not writable
    wr(16'h00FA);
    chk("R2 reserved bits ignored", int'(rd_data), int'(16'h0000));

    // R7: code change clears stable
    wr(16'h0101);
    repeat (8 * 2 + 2) @(negedge clk);
    chk("R7 stable set before code change", int'(rd_data[1]), 1);
    wr(16'h0201);
    chk("R7 stable clear after code change", int'(rd_data[1]), 0);
    chk("R7 new code visible", int'(rd_data[15:8]), 2);

    // R7: clearing the internal enable clears stable
    repeat (8 * 4 + 2) @(negedge clk);
    chk("R7 stable set before disable", int'(rd_data[1]), 1);
    wr(16'h0204);
    chk("R7 stable clear after disable", int'(rd_data[1]), 0);
    chk("R6 stable never without enable", int'(rd_data[1] && !rd_data[0]), 0);
    high_samples(16, hits);
    chk("R7 output silent with enable clear", hits, 0);

    // R8: zero write with card clock running
    wr(16'h0001);
    repeat (12) @(negedge clk);
    wr(16'h0005);
    repeat (6) @(negedge clk);
    wr(16'h0000);
    chk("R8 zero write with bypass clock running", int'(rd_data), 0);
    high_samples(20, hits);
    chk("R8 output stays low after zero write", hits, 0);

    wr(16'h0201);
    repeat (8 * 4 + 2) @(negedge clk);
    wr(16'h0205);
    repeat (20) @(negedge clk);
    wr(16'h0000);
    chk("R8 zero write with /4 clock running", int'(rd_data), 0);
    high_samples(20, hits);
    chk("R8 divided output stays low after zero write", hits, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule